// File: doc/BRIEF.md
# Drive Interface Status and Latch Glue

This block sits on the board between a disk controller's 8-bit auxiliary bus and the attached drives. The controller places a byte on the bus, marks its type with a 2-bit selector and pulses a strobe. The block keeps the drive-select/programmable-output byte (OUTPUT1) and the head/step byte (OUTPUT2) in latches. It turns every OUTPUT2 write into a step pulse and a direction level for the selected floppy drive.

In the other direction, the block builds the drive-status byte for the controller. It combines the drive lines with forced Ready and SeekComplete bits when a floppy is selected, or when a hard-drive select is active with no hard drive attached. The byte is registered. A one-cycle notify pulse follows every bus output, so the controller can take the refreshed status.

A small bit-addressed control register holds four bits: card select, the controller reset level and the two ROM page bits. One of the page bits also enables the switch-readout mode.

Top module: `drive_if_glue`

## Requirements
- R1: A strobe with selector 2'b01 loads the bus byte into OUTPUT1, and with selector 2'b11 into OUTPUT2, visible after that clock edge. Selectors 2'b00 and 2'b10 leave both latches unchanged.
- R2: Synchronous reset clears OUTPUT1, OUTPUT2, the status byte and all control bits, so `hdc_reset` is 1 after reset.
- R3: Status bit order from bit 7 down is ECC, Index, SeekComplete, Track00, User, WriteProtect, Ready, Fault. Bits 7 (ECC) and 3 (User) always read 0.
- R4: When OUTPUT1 bit 4 (floppy select) is 1, status bits 5 and 1 (mask 0x22) read 1.
- R5: When any of OUTPUT1 bits 7..5 (hard-drive selects) is 1 and `hd_present` is 0, status bits 5 and 1 read 1.
- R6: `drv_valid` is 0 when OUTPUT1[7:4] is zero. Otherwise `drv_idx` is the position (0..3) of the lowest set bit of OUTPUT1[7:4].
- R7: An OUTPUT2 strobe while OUTPUT1 bit 4 is 1 drives `step_n` low for STEP_W cycles, starting at the next edge. `dir_track0` becomes the inverse of bus bit 5 on every OUTPUT2 strobe.
- R8: Status bit 6 follows `flp_index`.
- R9: `status_push` is 1 for exactly the cycle after each strobe with a nonzero selector.
- R10: A control write to address 0 sets `card_sel`, and address 1 sets `hdc_reset` to the inverse of the written bit. Address 3 sets `rom_page[1]`. Address 4 sets `rom_page[0]` and `show_sw`. Addresses 2, 5, 6 and 7 have no effect.
- R11: The status byte is registered. It reflects the drive inputs and OUTPUT1 as they were one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ab_data | input | 8 | Auxiliary bus byte from the controller |
| ab_sel | input | 2 | Bus byte type selector |
| ab_stb | input | 1 | Bus write strobe, one cycle |
| flp_index | input | 1 | Index line of the selected drive |
| drv_seek | input | 1 | Seek complete line |
| drv_trk0 | input | 1 | Track 0 line |
| drv_wprot | input | 1 | Write protect line |
| drv_ready | input | 1 | Ready line |
| drv_fault | input | 1 | Fault line |
| hd_present | input | 1 | A hard drive is attached |
| ctl_wr | input | 1 | Control bit write enable |
| ctl_addr | input | 3 | Control bit address |
| ctl_bit | input | 1 | Control bit value |
| status | output | 8 | Registered drive-status byte |
| status_push | output | 1 | Status refresh notify pulse |
| out1 | output | 8 | OUTPUT1 latch |
| out2 | output | 8 | OUTPUT2 latch |
| drv_valid | output | 1 | Some drive selected |
| drv_idx | output | 2 | Selected drive index |
| step_n | output | 1 | Active-low step pulse |
| dir_track0 | output | 1 | 1 = step toward track 0 |
| card_sel | output | 1 | Card selected |
| hdc_reset | output | 1 | Controller reset, active high |
| rom_page | output | 2 | ROM page |
| show_sw | output | 1 | Switch-readout mode |

## Verification
The assertions check four things on every cycle: the always-zero ECC and User bits, the forced 0x22 bits after a floppy or an absent-drive select, the one-cycle index tracking and the push pulse after each output strobe. They also check that each step pulse traces back to an OUTPUT2 strobe and that the decoded drive index points at a set select bit. The bench's scenarios show the rest: the pulse width, the direction inversion, which selectors are ignored, the control-register bit mapping, the reset values and the full status byte under random drive lines and latch contents.

// File: rtl/drive_if_pkg.sv
package drive_if_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'b00,
        SEL_OUT1   = 2'b01,
        SEL_DMA    = 2'b10,
        SEL_OUT2   = 2'b11
    } ab_sel_e;

    typedef struct packed {
        logic ecc;
        logic index;
        logic seek;
        logic trk0;
        logic user;
        logic wprot;
        logic ready;
        logic fault;
    } stat_t;

    localparam logic [7:0] FORCE_MASK = 8'h22;
    localparam int FLP_BIT = 4;

    function automatic logic [1:0] lowest_sel(input logic [3:0] n);
        logic [1:0] r;
        r = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (n[i]) r = 2'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/aux_latch.sv
module aux_latch
    import drive_if_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] ab_data,
    input  logic [1:0] ab_sel,
    input  logic       ab_stb,
    output logic [7:0] out1_q,
    output logic [7:0] out2_q,
    output logic       push_q
);
    ab_sel_e sel;
    assign sel = ab_sel_e'(ab_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            out1_q <= '0;
            out2_q <= '0;
            push_q <= 1'b0;
        end else begin
            push_q <= ab_stb && (sel != SEL_STATUS);
            if (ab_stb && sel == SEL_OUT1) out1_q <= ab_data;
            if (ab_stb && sel == SEL_OUT2) out2_q <= ab_data;
        end
    end
endmodule

// File: rtl/step_gen.sv
module step_gen #(
    parameter int STEP_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic dir_bit,
    input  logic load_dir,
    output logic step_n,
    output logic toward0
);
    localparam int CW = (STEP_W > 1) ? $clog2(STEP_W) : 1;
    logic [CW-1:0] cnt;
    logic          low;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            low     <= 1'b0;
            toward0 <= 1'b0;
        end else begin
            if (load_dir) toward0 <= ~dir_bit;
            if (trig) begin
                low <= 1'b1;
                cnt <= CW'(STEP_W - 1);
            end else if (low) begin
                if (cnt == '0) low <= 1'b0;
                else           cnt <= cnt - 1'b1;
            end
        end
    end
    assign step_n = ~low;
endmodule

// File: rtl/ctl_bits.sv
module ctl_bits (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [2:0] addr,
    input  logic       bit_in,
    output logic       card_sel,
    output logic       hdc_reset,
    output logic [1:0] rom_page,
    output logic       show_sw
);
    logic b0, b1, b3, b4;

    always_ff @(posedge clk) begin
        if (rst) begin
            b0 <= 1'b0; b1 <= 1'b0; b3 <= 1'b0; b4 <= 1'b0;
        end else if (wr) begin
            case (addr)
                3'd0: b0 <= bit_in;
                3'd1: b1 <= bit_in;
                3'd3: b3 <= bit_in;
                3'd4: b4 <= bit_in;
                default: ;
            endcase
        end
    end
    assign card_sel  = b0;
    assign hdc_reset = ~b1;
    assign rom_page  = {b3, b4};
    assign show_sw   = b4;
endmodule

// File: rtl/drive_if_glue.sv
module drive_if_glue
    import drive_if_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] ab_data,
    input  logic [1:0] ab_sel,
    input  logic       ab_stb,
    input  logic       flp_index,
    input  logic       drv_seek,
    input  logic       drv_trk0,
    input  logic       drv_wprot,
    input  logic       drv_ready,
    input  logic       drv_fault,
    input  logic       hd_present,
    input  logic       ctl_wr,
    input  logic [2:0] ctl_addr,
    input  logic       ctl_bit,
    output logic [7:0] status,
    output logic       status_push,
    output logic [7:0] out1,
    output logic [7:0] out2,
    output logic       drv_valid,
    output logic [1:0] drv_idx,
    output logic       step_n,
    output logic       dir_track0,
    output logic       card_sel,
    output logic       hdc_reset,
    output logic [1:0] rom_page,
    output logic       show_sw
);
    logic out2_stb;
    stat_t raw;
    logic  hd_absent_sel;

    aux_latch u_latch (
        .clk(clk), .rst(rst), .ab_data(ab_data), .ab_sel(ab_sel), .ab_stb(ab_stb),
        .out1_q(out1), .out2_q(out2), .push_q(status_push)
    );

    assign out2_stb = ab_stb && (ab_sel_e'(ab_sel) == SEL_OUT2);

    step_gen #(.STEP_W(STEP_W)) u_step (
        .clk(clk), .rst(rst), .trig(out2_stb && out1[FLP_BIT]),
        .dir_bit(ab_data[5]), .load_dir(out2_stb),
        .step_n(step_n), .toward0(dir_track0)
    );

    ctl_bits u_ctl (
        .clk(clk), .rst(rst), .wr(ctl_wr), .addr(ctl_addr), .bit_in(ctl_bit),
        .card_sel(card_sel), .hdc_reset(hdc_reset), .rom_page(rom_page), .show_sw(show_sw)
    );

    assign drv_valid = |out1[7:4];
    assign drv_idx   = lowest_sel(out1[7:4]);
    assign hd_absent_sel = (|out1[7:5]) && !hd_present;

    always_comb begin
        raw = '{ecc: 1'b0, index: flp_index, seek: drv_seek, trk0: drv_trk0,
                user: 1'b0, wprot: drv_wprot, ready: drv_ready, fault: drv_fault};
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else if (out1[FLP_BIT] || hd_absent_sel) status <= raw | FORCE_MASK;
        else status <= raw;
    end
endmodule

// File: rtl/drive_if_glue_chk.sv
module drive_if_glue_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ab_sel,
    input logic       ab_stb,
    input logic       flp_index,
    input logic       hd_present,
    input logic [7:0] status,
    input logic       status_push,
    input logic [7:0] out1,
    input logic       drv_valid,
    input logic [1:0] drv_idx,
    input logic       step_n
);
    assert_zero_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (status[7] == 1'b0) && (status[3] == 1'b0));

    assert_floppy_force_R4: assert property (@(posedge clk) disable iff (rst)
        out1[4] |=> (status[5] && status[1]));

    assert_absent_force_R5: assert property (@(posedge clk) disable iff (rst)
        ((|out1[7:5]) && !hd_present) |=> (status[5] && status[1]));

    assert_idx_points_R6: assert property (@(posedge clk) disable iff (rst)
        drv_valid |-> out1[3'd4 + {1'b0, drv_idx}]);

    assert_step_origin_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(step_n) |-> $past(ab_stb && ab_sel == 2'b11 && out1[4]));

    assert_index_follow_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status[6] == $past(flp_index)));

    assert_push_R9: assert property (@(posedge clk) disable iff (rst)
        (ab_stb && ab_sel != 2'b00) |=> status_push);
endmodule

bind drive_if_glue drive_if_glue_chk u_chk (
    .clk(clk), .rst(rst), .ab_sel(ab_sel), .ab_stb(ab_stb), .flp_index(flp_index),
    .hd_present(hd_present), .status(status), .status_push(status_push), .out1(out1),
    .drv_valid(drv_valid), .drv_idx(drv_idx), .step_n(step_n)
);

// File: tb/drive_if_glue_test.sv
module drive_if_glue_test;
    localparam int CLK_P  = 10;
    localparam int STEP_W = 2;

    logic clk = 0, rst = 1;
    logic [7:0] ab_data = 0; logic [1:0] ab_sel = 0; logic ab_stb = 0;
    logic flp_index = 0, drv_seek = 0, drv_trk0 = 0, drv_wprot = 0, drv_ready = 0, drv_fault = 0;
    logic hd_present = 0, ctl_wr = 0, ctl_bit = 0; logic [2:0] ctl_addr = 0;
    logic [7:0] status, out1, out2; logic status_push, drv_valid, step_n, dir_track0;
    logic [1:0] drv_idx, rom_page; logic card_sel, hdc_reset, show_sw;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    drive_if_glue #(.STEP_W(STEP_W)) uut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic [5:0] ln, input logic hdp, input logic [7:0] o1);
        logic [7:0] s;
        s = {1'b0, ln[5], ln[4], ln[3], 1'b0, ln[2], ln[1], ln[0]};
        if (o1[4] || (o1[7:5] != 0 && !hdp)) s = s | 8'h22;
        return s;
    endfunction

    function automatic logic [2:0] exp_sel(input logic [7:0] o1);
        for (int i = 0; i < 4; i++) if (o1[4+i]) return {1'b1, 2'(i)};
        return 3'b000;
    endfunction

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); ab_sel = s; ab_data = d; ab_stb = 1;
        @(negedge clk); ab_stb = 0;
    endtask

    task automatic ctl_w(input logic [2:0] a, input logic b);
        @(negedge clk); ctl_addr = a; ctl_bit = b; ctl_wr = 1;
        @(negedge clk); ctl_wr = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2 reset state
        chk("R2 out1", out1, 8'h00);
        chk("R2 out2", out2, 8'h00);
        chk("R2 status", status, 8'h00);
        chk("R2 ctl", {4'b0, card_sel, hdc_reset, rom_page}, 8'h04);

        // R1 ignored selectors
        bus_wr(2'b01, 8'h3c);
        bus_wr(2'b10, 8'hff);
        chk("R1 dma sel ignored out1", out1, 8'h3c);
        bus_wr(2'b00, 8'hff);
        chk("R1 status sel ignored out1", out1, 8'h3c);
        chk("R1 status sel ignored out2", out2, 8'h00);

        // R7 step pulse with floppy selected, bit5 = 0 -> toward track 0
        bus_wr(2'b01, 8'h10);
        @(negedge clk); ab_sel = 2'b11; ab_data = 8'h00; ab_stb = 1;
        @(negedge clk); ab_stb = 0;
        chk("R7 step low 1", {7'b0, step_n}, 8'h00);
        chk("R7 dir toward0", {7'b0, dir_track0}, 8'h01);
        @(negedge clk);
        chk("R7 step low 2", {7'b0, step_n}, 8'h00);
        @(negedge clk);
        chk("R7 step released", {7'b0, step_n}, 8'h01);
        // bit5 = 1 -> away; no floppy select -> no pulse
        bus_wr(2'b01, 8'h20);
        @(negedge clk); ab_sel = 2'b11; ab_data = 8'h20; ab_stb = 1;
        @(negedge clk); ab_stb = 0;
        chk("R7 no step without floppy", {7'b0, step_n}, 8'h01);
        chk("R7 dir away", {7'b0, dir_track0}, 8'h00);

        // R5 hd select with/without drive present
        hd_present = 0; drv_ready = 0; drv_seek = 0;
        bus_wr(2'b01, 8'h40);
        @(negedge clk);
        chk("R5 absent forced", status & 8'h22, 8'h22);
        hd_present = 1;
        @(negedge clk); @(negedge clk);
        chk("R5 present not forced", status & 8'h22, 8'h00);

        // R10 control register
        ctl_w(3'd0, 1); ctl_w(3'd1, 1); ctl_w(3'd3, 1);
        chk("R10 after 0,1,3", {3'b0, card_sel, hdc_reset, rom_page, show_sw}, 8'h14);
        ctl_w(3'd4, 1);
        chk("R10 bit4", {3'b0, card_sel, hdc_reset, rom_page, show_sw}, 8'h17);
        ctl_w(3'd2, 0); ctl_w(3'd5, 0); ctl_w(3'd7, 0);
        chk("R10 unused addrs ignored", {3'b0, card_sel, hdc_reset, rom_page, show_sw}, 8'h17);
        ctl_w(3'd1, 0);
        chk("R10 reset asserted", {7'b0, hdc_reset}, 8'h01);

        // R11/R3/R4/R6/R8/R9/R1 random cycles
        begin
            logic [7:0] m_out1, m_out2, e_stat; logic e_push;
            m_out1 = out1; m_out2 = out2;
            e_stat = status; e_push = 0;
            for (int c = 0; c < 2000; c++) begin
                logic [5:0] ln; logic [2:0] es;
                @(negedge clk);
                if (c > 0) begin
                    chk("R11 R3 R4 R5 R8 status", status, e_stat);
                    chk("R9 push", {7'b0, status_push}, {7'b0, e_push});
                    chk("R1 out1", out1, m_out1);
                    chk("R1 out2", out2, m_out2);
                    es = exp_sel(out1);
                    chk("R6 select", {5'b0, drv_valid, drv_idx}, {5'b0, es});
                end
                ln = 6'($urandom);
                {flp_index, drv_seek, drv_trk0, drv_wprot, drv_ready, drv_fault} = ln;
                hd_present = 1'($urandom);
                ab_stb  = ($urandom % 3) == 0;
                ab_sel  = 2'($urandom);
                ab_data = 8'($urandom);
                e_stat = exp_status(ln, hd_present, m_out1);
                e_push = ab_stb && ab_sel != 2'b00;
                if (ab_stb && ab_sel == 2'b01) m_out1 = ab_data;
                if (ab_stb && ab_sel == 2'b11) m_out2 = ab_data;
            end
            @(negedge clk); ab_stb = 0;
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule